// File: doc/BRIEF.md
# Serial Bootstrap Program Loader

This block fills a 24-bit-wide program memory from an asynchronous serial byte stream and then hands off execution. Bytes arrive on a receive line framed as one start bit, eight data bits (least significant bit first) and one stop bit, with no parity. They are sampled with a 16x oversampling clock enable, `tick16`, that is supplied from outside. Each byte that is accepted is sent back out on the transmit line in the same frame format. A one-entry holding buffer sits in front of the transmitter, so reception continues while an earlier echo is still being shifted out.

The loader parses the stream in a fixed order. A three-byte word count comes first, then a three-byte load address, then the payload, which is that many program words of three bytes each. Every field is assembled least significant byte first, then the middle byte, then the most significant byte. Each word is written through a single-cycle write strobe to consecutive addresses, starting at the load address and wrapping modulo 2^24. After the last word the block raises a one-cycle `go` pulse and presents the load address as the entry point on `go_addr`. The parser then waits for a new count header.

The loader FSM has four states. `LD_COUNT` collects the count, and its third byte moves it to `LD_ADDR`. `LD_ADDR` collects the address; its third byte moves it to `LD_WORD`, or to `LD_GO` when the count is zero. `LD_WORD` collects words, and the third byte of the final word moves it to `LD_GO`. `LD_GO` lasts one cycle, accepts no byte, and always returns to `LD_COUNT`. The receiver FSM steps through `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_STOP` and back to `RX_IDLE`. From `RX_START` it falls back to `RX_IDLE` when the start bit fails its mid-bit check. The transmitter FSM moves from `TX_IDLE` to `TX_SEND` when the holding buffer is full, and returns to `TX_IDLE` after the stop bit.

Top module: `serial_boot_loader`

## Requirements
- R1: The first three accepted bytes after reset, or after a `go` pulse, form the 24-bit word count. The first byte is bits 7:0, the second is bits 15:8 and the third is bits 23:16.
- R2: The next three accepted bytes form the 24-bit load address, in the same byte order. The first word is written at this address.
- R3: Each program word is three accepted bytes in the same byte order. Each word is written with a single-cycle `mem_we` that carries `mem_addr` and `mem_wdata`. Successive words go to successive addresses, and the address wraps from 0xFFFFFF to 0x000000.
- R4: One cycle after the last word's write strobe, `go` is high for exactly one cycle and `go_addr` equals the load address. `go` and `mem_we` are never high in the same cycle.
- R5: A word count of zero produces no write. `go` follows the address header directly.
- R6: The receiver accepts 8N1 frames at 16 `tick16` enables per bit. It confirms the start bit at its 8th tick and samples each data bit at its centre, least significant bit first. A low pulse shorter than half a bit produces no byte.
- R7: A frame whose stop bit is sampled low raises `frame_err` for one cycle. That byte is neither parsed nor echoed.
- R8: Every accepted byte is retransmitted on `txd` in the order received, framed 8N1 at 16 `tick16` enables per bit. `txd` idles high.
- R9: A one-entry buffer holds an echo byte while the transmitter is busy. Bytes that arrive back to back, with no idle time between frames, are all parsed and all echoed without loss.
- R10: After `go`, the parser again expects a count header, so several images can be loaded one after another.
- R11: After reset, `txd` is high, and `mem_we`, `go` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable at 16x the baud rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line carrying the echo |
| mem_we | output | 1 | Single-cycle program memory write strobe |
| mem_addr | output | 24 | Write address |
| mem_wdata | output | 24 | Write data |
| go | output | 1 | One-cycle pulse to start execution |
| go_addr | output | 24 | Entry address, valid with `go` |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
One acceptance of a byte has several effects in the same cycle. When it is the third byte of a word, it commits the memory write, advances the address pointer and places the echo byte in the holding buffer. The buffer may at that moment still be waiting for the transmitter to finish the previous echo. The bench provokes this by sending every image as back-to-back frames with no idle time, so each new byte lands while the previous echo is still on `txd`. It judges the result by comparing the full write stream, including the address wrap, against the image. It also compares the full decoded echo stream against the bytes sent, and checks that `go` comes strictly after the last write.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int unsigned WORD_W = 24;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OSR    = 16;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
    typedef enum logic       {TX_IDLE, TX_SEND} tx_state_t;
    typedef enum logic [1:0] {LD_COUNT, LD_ADDR, LD_WORD, LD_GO} ld_state_t;
endpackage

// File: rtl/bl_uart_rx.sv
module bl_uart_rx
    import bl_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              take,
    output logic              valid,
    output logic [BYTE_W-1:0] data,
    output logic              frame_err
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned BIT_W = $clog2(BYTE_W);
    localparam int unsigned HALF  = OSR / 2;

    rx_state_t         state, nxt;
    logic              rx_m, rx_s;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] sr;
    logic              cnt_end, bit_end, half_pt;

    assign cnt_end = (cnt == CNT_W'(OSR - 1));
    assign half_pt = (cnt == CNT_W'(HALF - 1));
    assign bit_end = (bitn == BIT_W'(BYTE_W - 1));

    // two-flop synchronizer on the line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !rx_s)             nxt = RX_START;
            RX_START: if (tick && half_pt)           nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && cnt_end && bit_end) nxt = RX_STOP;
            RX_STOP:  if (tick && cnt_end)           nxt = RX_IDLE;
            default:                                 nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bitn      <= '0;
            sr        <= '0;
            valid     <= 1'b0;
            data      <= '0;
            frame_err <= 1'b0;
        end else begin
            frame_err <= 1'b0;
            if (take) valid <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt  <= '0;
                    bitn <= '0;
                end
                RX_START: if (tick) cnt <= half_pt ? '0 : cnt + 1'b1;
                RX_DATA: if (tick) begin
                    if (cnt_end) begin
                        cnt  <= '0;
                        sr   <= {rx_s, sr[BYTE_W-1:1]};
                        bitn <= bitn + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (cnt_end) begin
                        cnt <= '0;
                        if (rx_s) begin
                            valid <= 1'b1;
                            data  <= sr;
                        end else begin
                            frame_err <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/bl_echo_tx.sv
module bl_echo_tx
    import bl_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    output logic              ready,
    output logic              txd
);
    localparam int unsigned FRAME_W = BYTE_W + 2;
    localparam int unsigned CNT_W   = $clog2(OSR);
    localparam int unsigned BIT_W   = $clog2(FRAME_W);

    tx_state_t          state, nxt;
    logic               hold_v;
    logic [BYTE_W-1:0]  hold_d;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic               cnt_end, frame_end;

    assign cnt_end   = (cnt == CNT_W'(OSR - 1));
    assign frame_end = (bitn == BIT_W'(FRAME_W - 1));
    assign ready     = !hold_v;
    assign txd       = sh[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (hold_v)                          nxt = TX_SEND;
            TX_SEND: if (tick && cnt_end && frame_end)    nxt = TX_IDLE;
            default:                                      nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
            sh     <= '1;
            cnt    <= '0;
            bitn   <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (hold_v) begin
                    sh     <= {1'b1, hold_d, 1'b0};
                    cnt    <= '0;
                    bitn   <= '0;
                    hold_v <= 1'b0;
                end
                TX_SEND: if (tick) begin
                    if (cnt_end) begin
                        cnt  <= '0;
                        sh   <= {1'b1, sh[FRAME_W-1:1]};
                        bitn <= bitn + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: sh <= '1;
            endcase
            if (push) begin
                hold_v <= 1'b1;
                hold_d <= push_data;
            end
        end
    end
endmodule

// File: rtl/bl_loader_fsm.sv
module bl_loader_fsm
    import bl_pkg::*;
#(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              ready,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              go,
    output logic [WORD_W-1:0] go_addr
);
    localparam int unsigned NB    = WORD_W / BYTE_W;
    localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;

    ld_state_t         state, nxt;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] acc, full, left, ptr, base;
    logic              last;

    assign last  = (idx == IDX_W'(NB - 1));
    assign full  = {in_byte, acc[WORD_W-1:BYTE_W]};
    assign ready = (state != LD_GO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_COUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LD_COUNT: if (stb && last) nxt = LD_ADDR;
            LD_ADDR:  if (stb && last) nxt = (left == '0) ? LD_GO : LD_WORD;
            LD_WORD:  if (stb && last && left == WORD_W'(1)) nxt = LD_GO;
            LD_GO:    nxt = LD_COUNT;
            default:  nxt = LD_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            acc       <= '0;
            left      <= '0;
            ptr       <= '0;
            base      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            go        <= 1'b0;
            go_addr   <= '0;
        end else begin
            mem_we <= 1'b0;
            go     <= (state == LD_GO);
            if (state == LD_GO) go_addr <= base;
            if (stb) begin
                acc <= full;
                idx <= last ? '0 : idx + 1'b1;
                if (last) begin
                    unique case (state)
                        LD_COUNT: left <= full;
                        LD_ADDR: begin
                            ptr  <= full;
                            base <= full;
                        end
                        LD_WORD: begin
                            mem_we    <= 1'b1;
                            mem_addr  <= ptr;
                            mem_wdata <= full;
                            ptr       <= ptr + 1'b1;
                            left      <= left - 1'b1;
                        end
                        default: left <= left;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader
    import bl_pkg::*;
#(
    parameter int unsigned DATA_W = bl_pkg::WORD_W,
    parameter int unsigned CHAR_W = bl_pkg::BYTE_W,
    parameter int unsigned OVERS  = bl_pkg::OSR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    output logic              txd,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              go,
    output logic [DATA_W-1:0] go_addr,
    output logic              frame_err
);
    logic              rx_valid, echo_ready, ld_ready, accept;
    logic [CHAR_W-1:0] rx_data;

    // one acceptance feeds parser and echo together
    assign accept = rx_valid && echo_ready && ld_ready;

    bl_uart_rx #(.BYTE_W(CHAR_W), .OSR(OVERS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd), .take(accept),
        .valid(rx_valid), .data(rx_data), .frame_err(frame_err)
    );

    bl_echo_tx #(.BYTE_W(CHAR_W), .OSR(OVERS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .push(accept),
        .push_data(rx_data), .ready(echo_ready), .txd(txd)
    );

    bl_loader_fsm #(.WORD_W(DATA_W), .BYTE_W(CHAR_W)) u_ld (
        .clk(clk), .rst_n(rst_n), .stb(accept), .in_byte(rx_data),
        .ready(ld_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .go(go), .go_addr(go_addr)
    );
endmodule

// File: rtl/bl_checker.sv
module bl_checker #(
    parameter int unsigned DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic              go,
    input logic              frame_err
);
    logic              seen;
    logic [DATA_W-1:0] last_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            last_addr <= '0;
        end else if (go) begin
            seen <= 1'b0;
        end else if (mem_we) begin
            seen      <= 1'b1;
            last_addr <= mem_addr;
        end
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && seen) |-> mem_addr == last_addr + 1'b1); // R3
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) go |=> !go); // R4
    AST_GO_APART_WE: assert property (@(posedge clk) disable iff (!rst_n) !(go && mem_we)); // R4
    AST_FERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R7
endmodule

bind serial_boot_loader bl_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .go(go), .frame_err(frame_err)
);

// File: tb/tb_serial_boot_loader.sv
`timescale 1ns/1ps
module tb_serial_boot_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b1;
    logic        rxd = 1'b1;
    logic        txd, mem_we, go, frame_err;
    logic [23:0] mem_addr, mem_wdata, go_addr;

    always #2 clk = ~clk;

    serial_boot_loader dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .txd(txd),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .go(go), .go_addr(go_addr), .frame_err(frame_err)
    );

    // image table: count, address, word0..word2
    localparam logic [23:0] VEC [4][5] = '{
        '{24'd2, 24'h000100, 24'h123456, 24'hABCDEF, 24'h0},
        '{24'd3, 24'hFFFFFE, 24'h0F1E2D, 24'h3C4B5A, 24'h697887},
        '{24'd3, 24'h00A5A5, 24'h000000, 24'hFFFFFF, 24'h800001},
        '{24'd0, 24'h00FACE, 24'h0, 24'h0, 24'h0}
    };

    int compared = 0, mismatched = 0;
    int cyc = 0;
    bit done = 0;

    logic [23:0] wr_a [8];
    logic [23:0] wr_d [8];
    int          wr_n = 0, wr_cyc = 0;
    logic [23:0] go_a = '0;
    int          go_n = 0, go_cyc = 0, ferr_n = 0;
    logic [7:0]  echo [64];
    int          echo_n = 0;
    logic [7:0]  sent [64];
    int          sent_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (rst_n) begin
        if (mem_we) begin
            if (wr_n < 8) begin
                wr_a[wr_n] = mem_addr;
                wr_d[wr_n] = mem_wdata;
            end
            wr_n++;
            wr_cyc = cyc;
        end
        if (go) begin
            go_n++;
            go_a = go_addr;
            go_cyc = cyc;
        end
        if (frame_err) ferr_n++;
    end

    // decode the echo line at bit centres
    initial forever begin
        logic [7:0] b;
        @(negedge txd);
        repeat (8) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (16) @(negedge clk);
            b[i] = txd;
        end
        repeat (16) @(negedge clk);
        if (echo_n < 64) echo[echo_n] = b;
        echo_n++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good);
        @(negedge clk) rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (16) @(negedge clk);
        end
        if (good) begin
            rxd = 1'b1;
            if (sent_n < 64) sent[sent_n] = b;
            sent_n++;
            repeat (15) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (12) @(negedge clk);
            rxd = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic send_word(input logic [23:0] w);
        send_byte(w[7:0], 1'b1);
        send_byte(w[15:8], 1'b1);
        send_byte(w[23:16], 1'b1);
    endtask

    task automatic clear_logs();
        wr_n = 0; go_n = 0; echo_n = 0; sent_n = 0; ferr_n = 0;
    endtask

    task automatic check_echo(input string tag);
        chk(echo_n == sent_n, {tag, " echo count"}, echo_n, sent_n);
        for (int k = 0; k < sent_n && k < 64; k++)
            chk(echo[k] == sent[k], {tag, " echo byte"}, echo[k], sent[k]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(txd == 1'b1, "R11 txd idle", txd, 1);
        chk(mem_we == 1'b0, "R11 mem_we", mem_we, 0);
        chk(go == 1'b0, "R11 go", go, 0);
        chk(frame_err == 1'b0, "R11 frame_err", frame_err, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // table of images, loaded back to back (R10)
        for (int v = 0; v < 4; v++) begin
            int n;
            clear_logs();
            n = int'(VEC[v][0]);
            send_word(VEC[v][0]);
            send_word(VEC[v][1]);
            for (int j = 0; j < n; j++) send_word(VEC[v][2+j]);
            repeat (400) @(negedge clk);
            chk(wr_n == n, "R1 R5 write count", wr_n, n);
            for (int j = 0; j < n && j < wr_n; j++) begin
                logic [23:0] ea;
                ea = VEC[v][1] + 24'(j);
                chk(wr_a[j] == ea, (j == 0) ? "R2 first address" : "R3 address step", wr_a[j], ea);
                chk(wr_d[j] == VEC[v][2+j], "R3 R6 word data", wr_d[j], VEC[v][2+j]);
            end
            chk(go_n == 1, "R4 R10 go count", go_n, 1);
            chk(go_a == VEC[v][1], "R4 go_addr", go_a, VEC[v][1]);
            if (n > 0) chk(go_cyc == wr_cyc + 1, "R4 go after last write", go_cyc, wr_cyc + 1);
            check_echo("R8 R9");
        end

        // R6 short low glitch gives no byte
        clear_logs();
        @(negedge clk) rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk(echo_n == 0, "R6 glitch rejected", echo_n, 0);

        // R7 low stop bit: flagged, not parsed, not echoed
        clear_logs();
        send_byte(8'h5A, 1'b0);
        repeat (300) @(negedge clk);
        chk(ferr_n == 1, "R7 frame_err pulse", ferr_n, 1);
        chk(echo_n == 0, "R7 no echo", echo_n, 0);
        // parser state unaffected: a one-word image still loads correctly
        clear_logs();
        send_word(24'd1);
        send_word(24'h000042);
        send_word(24'hC0FFEE);
        repeat (400) @(negedge clk);
        chk(wr_n == 1, "R7 parse intact count", wr_n, 1);
        chk(wr_a[0] == 24'h000042, "R7 parse intact addr", wr_a[0], 24'h000042);
        chk(wr_d[0] == 24'hC0FFEE, "R7 parse intact data", wr_d[0], 24'hC0FFEE);
        chk(go_n == 1 && go_a == 24'h000042, "R7 go after recovery", go_a, 24'h000042);
        check_echo("R7 R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired act=%0d exp=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule